// File: doc/BRIEF.md
# AES-128 Encryption Pipeline

The block encrypts one 128-bit block under a 128-bit cipher key with the standard ten-round AES-128 cipher. A clock register sits behind every single transformation: the initial key whitening, and then each SubBytes, ShiftRows, MixColumns and AddRoundKey step. A valid bit travels with the data from register to register, and a stage register only loads when the valid bit arriving at it is set. This gives a fixed latency of forty cycles.

Round keys are derived on the fly from the cipher key. A single key register steps forward once per round, just after the previous AddRoundKey stage has captured its result. The core therefore holds only one block at a time. A strobe that arrives while a block is inside the core is dropped. The ciphertext output keeps its value between completions, so a consumer may sample it at any time after the completion pulse.

Top module: `aes128_enc_pipe`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `cipher_o` is all zeros. Reset acts asynchronously and clears every stage register and the held round key.
- R2: Blocks and keys are byte strings, with byte 0 at bits [127:120], and the state is filled column by column, four bytes per column. With key 000102030405060708090a0b0c0d0e0f and data 00112233445566778899aabbccddeeff, `cipher_o` becomes 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: With key 2b7e151628aed2a6abf7158809cf4f3c and data 3243f6a8885a308d313198a2e0370734, `cipher_o` becomes 3925841d02dc09fbdc118597196a0b32.
- R4: A block is accepted at a rising edge where `valid_i` is 1 and the core is empty. Counting that edge as the first, `valid_o` rises after the fortieth edge and stays high for exactly one cycle.
- R5: `cipher_o` changes only at the edge that raises `valid_o`. Otherwise it keeps the last ciphertext.
- R6: `valid_i` is ignored from the accepting edge up to and including the edge that ends the `valid_o` cycle. Neither the data nor the key presented there affects the result, and no extra completion follows. At most one block is inside the core.
- R7: For any key and data, `cipher_o` equals the AES-128 encryption. Each block uses its own key. With `valid_i` held high, a new block is accepted every 41 cycles.
- R8: Asserting reset while a block is in flight aborts it at once. No completion for that block appears after reset is released, and the next block encrypts correctly.
- R9: An all-zero key with all-zero data gives 66e94bd4ef8a2c3b884cfa59ca342b2e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request to start a block with the present key and data |
| key_i | input | 128 | Cipher key, sampled at the accepting edge |
| data_i | input | 128 | Plaintext block, sampled at the accepting edge |
| valid_o | output | 1 | One-cycle pulse when a new ciphertext is on `cipher_o` |
| cipher_o | output | 128 | Ciphertext of the last completed block, held |

## Verification
A wrong byte in any stage register, or a round key stepped at the wrong moment, stays hidden until the block leaves the core. It then shows as a wrong `cipher_o` exactly forty cycles after acceptance. A lost, duplicated or misplaced valid bit shows earlier. It appears as a missing or extra `valid_o` pulse, or as a strobe that is accepted or refused at the wrong edge, and a cycle-accurate model compared on every clock flags it in the first cycle the ports differ from it.

// File: rtl/aes_pkg.sv
package aes_pkg;

  typedef logic [7:0]   byte_t;
  typedef logic [31:0]  word_t;
  typedef logic [127:0] block_t;

  typedef enum logic [1:0] {STEP_SUB, STEP_SHIFT, STEP_MIX, STEP_PASS} step_e;

  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc = 8'h00;
    byte_t p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254 is the field inverse; 0 maps to 0
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r = 8'h01;
    byte_t p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic block_t shift_rows(input block_t s);
    block_t o;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic block_t mix_columns(input block_t s);
    block_t o;
    byte_t  a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      o[103-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return o;
  endfunction

  function automatic word_t sub_word(input word_t w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  // round constant for step idx (0 -> 01)
  function automatic byte_t rcon(input int unsigned idx);
    byte_t r = 8'h01;
    for (int unsigned i = 0; i < 16; i++) begin
      if (i < idx) r = xtime(r);
    end
    return r;
  endfunction

  function automatic block_t key_next(input block_t k, input byte_t rc);
    word_t w0, w1, w2, w3, t;
    w0 = k[127:96];
    w1 = k[95:64];
    w2 = k[63:32];
    w3 = k[31:0];
    t  = sub_word({w3[23:0], w3[31:24]}) ^ {rc, 24'h000000};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  // 0 sub, 1 shift, 2 mix, 3 key add
  function automatic int unsigned stage_role(input int unsigned s, input int unsigned nr);
    int unsigned last_base;
    last_base = 4 * (nr - 1) + 1;
    if (s == 0) return 3;
    if (s >= last_base) return ((s - last_base) == 2) ? 3 : (s - last_base);
    return (s - 1) % 4;
  endfunction

endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
  import aes_pkg::*;
#(
  parameter int unsigned NB = 16
) (
  input  logic [8*NB-1:0] din_i,
  output logic [8*NB-1:0] dout_o
);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout_o[8*b +: 8] = sbox(din_i[8*b +: 8]);
  end

endmodule

// File: rtl/aes_stage.sv
module aes_stage
  import aes_pkg::*;
#(
  parameter step_e KIND = STEP_PASS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [127:0] state_i,
  output logic         valid_o,
  output logic [127:0] state_o
);

  block_t next_w;

  if (KIND == STEP_SUB) begin : g_sub
    aes_sub_bytes #(.NB(16)) u_sub (
      .din_i (state_i),
      .dout_o(next_w)
    );
  end else if (KIND == STEP_SHIFT) begin : g_shift
    assign next_w = shift_rows(state_i);
  end else if (KIND == STEP_MIX) begin : g_mix
    assign next_w = mix_columns(state_i);
  end else begin : g_pass
    assign next_w = state_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      state_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) state_o <= next_w;
    end
  end

endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [127:0] key_i,
  input  logic         step_i,
  output logic [127:0] rkey_o
);

  localparam int unsigned CW = $clog2(NUM_ROUNDS + 1);

  block_t        key_q;
  logic [CW-1:0] rnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      rnd_q <= '0;
    end else if (load_i) begin
      key_q <= key_i;
      rnd_q <= '0;
    end else if (step_i) begin
      key_q <= key_next(key_q, rcon(32'(rnd_q)));
      rnd_q <= rnd_q + 1'b1;
    end
  end

  assign rkey_o = key_q;

endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
  import aes_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [127:0] key_i,
  input  logic [127:0] data_i,
  output logic         valid_o,
  output logic [127:0] cipher_o
);

  localparam int unsigned NUM_STAGES = 4 * NUM_ROUNDS;

  logic [NUM_STAGES-1:0] v_q;
  logic [NUM_STAGES-1:0] v_in;
  logic [NUM_STAGES-1:0] adv_w;
  block_t                st_q  [NUM_STAGES];
  block_t                st_in [NUM_STAGES];
  block_t                rkey_w;
  logic                  idle_w, accept_w, step_w;

  assign idle_w   = ~|v_q;
  assign accept_w = valid_i & idle_w;
  assign step_w   = |adv_w;

  aes_key_sched #(.NUM_ROUNDS(NUM_ROUNDS)) u_ksched (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept_w),
    .key_i (key_i),
    .step_i(step_w),
    .rkey_o(rkey_w)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int unsigned ROLE = stage_role(s, NUM_ROUNDS);
    localparam step_e KIND = (ROLE == 0) ? STEP_SUB :
                             (ROLE == 1) ? STEP_SHIFT :
                             (ROLE == 2) ? STEP_MIX : STEP_PASS;
    block_t prev_w;
    logic   prev_v;

    if (s == 0) begin : g_head
      assign prev_w = data_i;
      assign prev_v = accept_w;
    end else begin : g_link
      assign prev_w = st_q[s-1];
      assign prev_v = v_q[s-1];
    end

    if (ROLE == 3) begin : g_ark
      if (s == 0) begin : g_whiten
        assign st_in[s] = prev_w ^ key_i;
      end else begin : g_round
        assign st_in[s] = prev_w ^ rkey_w;
      end
      // the key steps once its consumer has captured, except after the last one
      if (s < NUM_STAGES - 1) begin : g_adv
        assign adv_w[s] = v_q[s];
      end else begin : g_noadv
        assign adv_w[s] = 1'b0;
      end
    end else begin : g_xform
      assign st_in[s] = prev_w;
      assign adv_w[s] = 1'b0;
    end

    assign v_in[s] = prev_v;

    aes_stage #(.KIND(KIND)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(v_in[s]),
      .state_i(st_in[s]),
      .valid_o(v_q[s]),
      .state_o(st_q[s])
    );
  end

  assign valid_o  = v_q[NUM_STAGES-1];
  assign cipher_o = st_q[NUM_STAGES-1];

endmodule

module aes128_enc_pipe_chk #(
  parameter int unsigned NUM_ROUNDS = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic [127:0]            cipher_o,
  input logic                    idle_i,
  input logic [4*NUM_ROUNDS-1:0] stage_v_i
);

  localparam int unsigned NS = 4 * NUM_ROUNDS;
  localparam int unsigned LW = $clog2(NS + 1);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (valid_i && idle_i) lat_q <= LW'(1);
    else if (lat_q == LW'(NS)) lat_q <= '0;
    else if (lat_q != '0) lat_q <= lat_q + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && cipher_o == '0)); // R1

  AST_DONE_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LW'(NS)) |-> valid_o); // R4

  AST_NO_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lat_q == LW'(NS))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4

  AST_CT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cipher_o) |-> valid_o); // R5

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stage_v_i) <= 1); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lat_q != '0 && lat_q != LW'(NS)) |=> (lat_q == $past(lat_q) + 1'b1)); // R6

endmodule

bind aes128_enc_pipe aes128_enc_pipe_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .cipher_o (cipher_o),
  .idle_i   (idle_w),
  .stage_v_i(v_q)
);

// File: tb/tb_aes128_enc_pipe.sv
module tb_aes128_enc_pipe;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         vin = 1'b0;
  logic [127:0] key = '0;
  logic [127:0] pt = '0;
  logic         valid_o;
  logic [127:0] ct;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  aes128_enc_pipe dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (vin),
    .key_i   (key),
    .data_i  (pt),
    .valid_o (valid_o),
    .cipher_o(ct)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected<=20000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // ---- behavioural reference cipher ----
  logic [7:0] sb [256];

  function automatic logic [7:0] mul2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  initial begin
    logic [7:0] ex [256];
    int         lg [256];
    logic [7:0] x, inv, v;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = x;
      lg[x] = i;
      x = x ^ mul2(x);
    end
    sb[0] = 8'h63;
    for (int a = 1; a < 256; a++) begin
      inv = ex[(255 - lg[a]) % 255];
      v = inv;
      sb[a] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
              {v[3:0], v[7:4]} ^ 8'h63;
    end
  end

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] rk [16];
    logic [7:0] tmp [4];
    logic [7:0] rc;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      s[i]  = p[127-8*i -: 8] ^ rk[i];
    end
    rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      tmp[0] = sb[rk[13]] ^ rc;
      tmp[1] = sb[rk[14]];
      tmp[2] = sb[rk[15]];
      tmp[3] = sb[rk[12]];
      for (int j = 0; j < 4; j++) rk[j] = rk[j] ^ tmp[j];
      for (int j = 4; j < 16; j++) rk[j] = rk[j] ^ rk[j-4];
      rc = mul2(rc);
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++)
          t[4*c+w] = sb[s[4*((c+w)%4)+w]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++)
          if (r < 10)
            s[4*c+w] = mul2(t[4*c+w]) ^ mul2(t[4*c+(w+1)%4]) ^ t[4*c+(w+1)%4] ^
                       t[4*c+(w+2)%4] ^ t[4*c+(w+3)%4];
          else
            s[4*c+w] = t[4*c+w];
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // ---- cycle model ----
  int           rem = 0;
  logic         m_valid = 1'b0;
  logic [127:0] m_ct = '0;
  logic [127:0] m_pend = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem = 0;
      m_valid = 1'b0;
      m_ct = '0;
    end else begin
      bit acc;
      bit fin;
      acc = vin && rem == 0 && !m_valid;
      fin = (rem == 1);
      if (rem > 0) rem--;
      m_valid = fin;
      if (fin) m_ct = m_pend;
      if (acc) begin
        rem = 39;
        m_pend = ref_enc(pt, key);
      end
    end
  end

  always @(negedge clk) begin
    check(valid_o === m_valid && ct === m_ct,
          $sformatf("R7 cycle model valid=%b exp_valid=%b", valid_o, m_valid), ct, m_ct);
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_block(input logic [127:0] k, input logic [127:0] d,
                           output int lat, output logic [127:0] res);
    int c0;
    @(negedge clk);
    vin = 1'b1; key = k; pt = d;
    @(negedge clk);
    vin = 1'b0;
    c0 = cyc;
    while (valid_o !== 1'b1) @(negedge clk);
    lat = cyc - c0 + 1;
    res = ct;
  endtask

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] CT_Z  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  initial begin
    int lat;
    int done;
    logic [127:0] res;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0, "R1 valid_o in reset", {127'd0, valid_o}, 128'd0);
    check(ct === '0, "R1 cipher_o in reset", ct, 128'd0);
    rst_n = 1'b1;

    // R2 and R4
    run_block(KEY_A, PT_A, lat, res);
    check(res === CT_A, "R2 vector A", res, CT_A);
    check(lat == 40, "R4 latency", 128'(lat), 128'd40);
    @(negedge clk);
    check(valid_o === 1'b0, "R4 single-cycle pulse", {127'd0, valid_o}, 128'd0);
    repeat (30) @(negedge clk);
    check(ct === CT_A, "R5 ciphertext held", ct, CT_A);

    // R3 with R6: strobe kept high with junk for the whole flight
    @(negedge clk);
    vin = 1'b1; key = KEY_B; pt = PT_B;
    @(negedge clk);
    lat = 1;
    key = rnd128(); pt = rnd128();
    while (valid_o !== 1'b1) begin
      @(negedge clk);
      key = rnd128(); pt = rnd128();
      lat++;
    end
    check(ct === CT_B, "R3 vector B under busy strobes", ct, CT_B);
    check(lat == 40, "R6 latency unaffected by busy strobes", 128'(lat), 128'd40);
    @(negedge clk);
    vin = 1'b0;
    done = 0;
    repeat (60) begin
      @(negedge clk);
      if (valid_o === 1'b1) done++;
    end
    check(done == 0, "R6 no completion from ignored strobes", 128'(done), 128'd0);
    check(ct === CT_B, "R6 cipher_o untouched by ignored strobes", ct, CT_B);

    // R9
    run_block('0, '0, lat, res);
    check(res === CT_Z, "R9 zero key and data", res, CT_Z);

    // R7: continuous strobe, fresh random key and data every cycle
    done = 0;
    for (int i = 0; i < 210; i++) begin
      @(negedge clk);
      if (valid_o === 1'b1) done++;
      vin = 1'b1; key = rnd128(); pt = rnd128();
    end
    @(negedge clk);
    vin = 1'b0;
    check(done == 5, "R7 one block per 41 cycles", 128'(done), 128'd5);
    repeat (60) @(negedge clk);

    // R8: reset in flight
    @(negedge clk);
    vin = 1'b1; key = KEY_B; pt = PT_B;
    @(negedge clk);
    vin = 1'b0;
    repeat (20) @(negedge clk);
    #5 rst_n = 1'b0;
    #1;
    check(valid_o === 1'b0, "R8 valid_o cleared by reset", {127'd0, valid_o}, 128'd0);
    check(ct === '0, "R8 cipher_o cleared by reset", ct, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 0;
    repeat (60) begin
      @(negedge clk);
      if (valid_o === 1'b1) done++;
    end
    check(done == 0, "R8 aborted block never completes", 128'(done), 128'd0);
    run_block(KEY_A, PT_A, lat, res);
    check(res === CT_A, "R8 recovery after reset", res, CT_A);
    check(lat == 40, "R8 latency after reset", 128'(lat), 128'd40);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule